// File: doc/BRIEF.md
# Attribute Register File with Shared Index/Data Port

This block is a bank of 8-bit attribute registers reached from an 8-bit I/O bus through one shared write port. A hidden toggle decides what each write to that port does. When the toggle is clear, the byte goes into the index register. When it is set, the byte goes into the attribute register that the index selects. Every write to the shared port flips the toggle. Software reads the current index back from the shared port and reads the selected register from a second, read-only port.

Software has no direct way to set the toggle to a known state. Instead, any read of the status port clears it, so the next write to the shared port is taken as an index. The status read also returns the sampled vertical-retrace and display-disabled flags. Diagnostic code can read the toggle itself through a small CRTC-style index/data pair: the toggle appears in bit 7 of extended index 24h.

The index register also holds a display-enable bit, which drives an output pin. The contents of all registers are brought out on a flat bus for downstream logic.

Top module: `attr_flop_port`

## Requirements
- R1: After reset the toggle is 0, the index register is 00h, every attribute register is 00h, the CRTC-style index is 00h and both sampled status flags are 0.
- R2: The shared port is at 3C0h. A write to it with the toggle at 0 loads bits 5:0 of the byte into the index register. A write to it with the toggle at 1 loads the whole byte into the attribute register selected by index bits 4:0. Every write to 3C0h inverts the toggle.
- R3: A read of 3C0h returns the index register as {2'b00, enable bit, 5-bit index}. Bits 7:6 always read 0.
- R4: A read of 3C1h returns the attribute register selected by the index. With the default NUM_ATTR = 21, indices 0 to 20 are implemented, and a read of any index from NUM_ATTR to 31 returns 00h.
- R5: A data write to an unimplemented index changes no attribute register.
- R6: Any read of the status port 3DAh sets the toggle to 0, whatever its previous value. The next write to 3C0h is then taken as an index.
- R7: A read of 3DAh returns the vertical-retrace pin in bit 3 and the display-disabled pin in bit 0, both as registered one clock earlier. All other bits read 0.
- R8: A write to 3D4h sets the CRTC-style index, and a read of 3D4h returns it. A read of 3D5h returns {toggle, 7'b0} when that index is 24h and 00h for any other index.
- R9: Reads of 3C0h, 3C1h, 3D4h and 3D5h leave the toggle unchanged.
- R10: The output attr_video_en equals bit 5 of the index register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 16 | I/O port address |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data; valid in the same cycle as io_rd, 00h otherwise |
| vretrace | input | 1 | Vertical retrace in progress |
| disp_off | input | 1 | Display disabled (blanking) |
| attr_video_en | output | 1 | Display-enable bit from the index register |
| attr_regs | output | 8*NUM_ATTR | All attribute registers, index 0 in the low byte |

## Verification
The bench uses the default NUM_ATTR = 21. With this value the 5-bit index covers both implemented registers (0 to 20) and unimplemented ones (21 to 31), so random index writes reach both the discard path and the read-as-zero path. Random sequences mix shared-port writes with status-port reads at arbitrary points. This leaves the toggle in either state when the status port is read, and when the extended register is read back. Directed cases cover the all-ones index write, the highest index, and a status read between an index write and its data write.

// File: rtl/attr_flop_port.sv
module attr_flop_port #(
  parameter int NUM_ATTR = 21,
  parameter logic [15:0] P_SHARED = 16'h03C0,
  parameter logic [15:0] P_DATA_RD = 16'h03C1,
  parameter logic [15:0] P_STATUS = 16'h03DA,
  parameter logic [15:0] P_EXT_IX = 16'h03D4,
  parameter logic [15:0] P_EXT_DT = 16'h03D5,
  parameter logic [7:0]  EXT_FLOP_IX = 8'h24
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [15:0]           io_addr,
  input  logic                  io_wr,
  input  logic                  io_rd,
  input  logic [7:0]            io_wdata,
  output logic [7:0]            io_rdata,
  input  logic                  vretrace,
  input  logic                  disp_off,
  output logic                  attr_video_en,
  output logic [8*NUM_ATTR-1:0] attr_regs
);
  localparam int IW = 5;
  localparam logic [IW:0] NUM_L = NUM_ATTR[IW:0];

  logic             tog_q;
  logic [IW:0]      ix_q;
  logic [7:0]       ext_ix_q;
  logic             vret_q, doff_q;
  logic [7:0]       bank [NUM_ATTR];

  wire wr_shared = io_wr && (io_addr == P_SHARED);
  wire wr_ext_ix = io_wr && (io_addr == P_EXT_IX);
  wire rd_status = io_rd && (io_addr == P_STATUS);
  wire [IW-1:0] sel = ix_q[IW-1:0];
  wire sel_ok = {1'b0, sel} < NUM_L;

  assign attr_video_en = ix_q[IW];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tog_q <= 1'b0;
      ix_q <= '0;
      ext_ix_q <= '0;
      vret_q <= 1'b0;
      doff_q <= 1'b0;
      for (int i = 0; i < NUM_ATTR; i++) bank[i] <= '0;
    end else begin
      vret_q <= vretrace;
      doff_q <= disp_off;
      if (wr_ext_ix) ext_ix_q <= io_wdata;
      if (wr_shared) begin
        tog_q <= ~tog_q;
        if (!tog_q) ix_q <= io_wdata[IW:0];
        else if (sel_ok) bank[sel] <= io_wdata;
      end else if (rd_status) begin
        tog_q <= 1'b0;
      end
    end
  end

  logic [7:0] sel_data;
  always_comb begin
    sel_data = 8'h00;
    for (int i = 0; i < NUM_ATTR; i++)
      if ({1'b0, sel} == i[IW:0]) sel_data = bank[i];
  end

  always_comb begin
    io_rdata = 8'h00;
    if (io_rd) begin
      case (io_addr)
        P_SHARED:  io_rdata = {2'b00, ix_q};
        P_DATA_RD: io_rdata = sel_data;
        P_STATUS:  io_rdata = {4'b0000, vret_q, 2'b00, doff_q};
        P_EXT_IX:  io_rdata = ext_ix_q;
        P_EXT_DT:  io_rdata = (ext_ix_q == EXT_FLOP_IX) ? {tog_q, 7'b0} : 8'h00;
        default:   io_rdata = 8'h00;
      endcase
    end
  end

  for (genvar g = 0; g < NUM_ATTR; g++) begin : g_out
    assign attr_regs[8*g +: 8] = bank[g];
  end

  assert_status_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_status |=> !tog_q);
  assert_write_flips_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_shared |=> (tog_q != $past(tog_q)));
  assert_index_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_shared && !tog_q) |=> (ix_q == $past(io_wdata[IW:0])));
  assert_toggle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_shared && !rd_status) |=> $stable(tog_q));
  assert_index_top_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && io_addr == P_SHARED) |-> (io_rdata[7:6] == 2'b00));
  assert_status_pads_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_status |-> (io_rdata[7:4] == 4'h0 && io_rdata[2:1] == 2'b00));
  assert_video_en_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_shared && !tog_q) |=> (attr_video_en == $past(io_wdata[5])));
endmodule

// File: tb/tb_attr_flop_port.sv
module tb_attr_flop_port;
  localparam int CLK_PERIOD = 10;
  localparam int NA = 21;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] io_addr = '0;
  logic io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0] io_wdata = '0;
  logic [7:0] io_rdata;
  logic vretrace = 1'b0, disp_off = 1'b0;
  logic attr_video_en;
  logic [8*NA-1:0] attr_regs;

  attr_flop_port #(.NUM_ATTR(NA)) dut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .vretrace(vretrace),
    .disp_off(disp_off), .attr_video_en(attr_video_en), .attr_regs(attr_regs));

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, bad = 0;
  logic tog_m = 1'b0;
  logic [5:0] ix_m = '0;
  logic [7:0] ext_m = '0;
  logic [7:0] regs_m [32];
  logic vret_m = 1'b0, doff_m = 1'b0;
  bit done = 1'b0;

  function automatic logic [7:0] exp_data();
    return (ix_m[4:0] < NA) ? regs_m[ix_m[4:0]] : 8'h00;
  endfunction
  function automatic logic [7:0] exp_status();
    return {4'h0, vret_m, 2'b00, doff_m};
  endfunction
  function automatic logic [7:0] exp_ext();
    return (ext_m == 8'h24) ? {tog_m, 7'b0} : 8'h00;
  endfunction

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%02h exp=%02h", req, got, exp);
    end
  endtask

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(posedge clk);
    if (a == 16'h03C0) begin
      if (!tog_m) ix_m = d[5:0];
      else if (ix_m[4:0] < NA) regs_m[ix_m[4:0]] = d;
      tog_m = ~tog_m;
    end else if (a == 16'h03D4) ext_m = d;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic io_read(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    #1 d = io_rdata;
    @(posedge clk);
    if (a == 16'h03DA) tog_m = 1'b0;
    @(negedge clk);
    io_rd = 1'b0;
  endtask

  task automatic set_pins(input logic v, input logic o);
    @(negedge clk);
    vretrace = v; disp_off = o;
    @(posedge clk);
    vret_m = v; doff_m = o;
  endtask

  task automatic check_all_regs(input string req);
    for (int i = 0; i < NA; i++) check(req, attr_regs[8*i +: 8], regs_m[i]);
  endtask

  initial begin
    #(CLK_PERIOD*60000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] r;
    void'($urandom(32'h1234_5678));
    for (int i = 0; i < 32; i++) regs_m[i] = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    io_read(16'h03C0, r); check("R1 index", r, 8'h00);
    io_read(16'h03C1, r); check("R1 data", r, 8'h00);
    io_read(16'h03D5, r); check("R1 ext", r, 8'h00);
    io_write(16'h03D4, 8'h24);
    io_read(16'h03D4, r); check("R8 ext index", r, 8'h24);
    io_read(16'h03D5, r); check("R1 toggle", r, 8'h00);
    check_all_regs("R1 regs");

    io_write(16'h03C0, 8'hFF);
    io_read(16'h03C0, r); check("R3 top bits", r, 8'h3F);
    check("R10 enable", {7'b0, attr_video_en}, 8'h01);
    io_read(16'h03D5, r); check("R8 toggle after index", r, 8'h80);
    io_read(16'h03C1, r); check("R9 toggle after reads", {7'b0, tog_m}, 8'h01);
    io_read(16'h03D5, r); check("R9 toggle kept", r, 8'h80);
    io_write(16'h03C0, 8'hA5);
    check_all_regs("R5 idx31 discard");
    io_read(16'h03C1, r); check("R4 unimpl read", r, 8'h00);

    io_write(16'h03C0, 8'h05);
    io_read(16'h03DA, r); check("R7 status", r, exp_status());
    io_read(16'h03D5, r); check("R6 cleared", r, 8'h00);
    io_write(16'h03C0, 8'h07);
    io_read(16'h03C0, r); check("R6 next is index", r, 8'h07);
    check("R10 enable low", {7'b0, attr_video_en}, 8'h00);
    io_write(16'h03C0, 8'h5A);
    io_read(16'h03C1, r); check("R2 data write", r, 8'h5A);
    io_write(16'h03C0, 8'h14);
    io_write(16'h03C0, 8'hC3);
    io_read(16'h03C1, r); check("R4 top implemented", r, 8'hC3);
    set_pins(1'b1, 1'b1);
    io_read(16'h03DA, r); check("R7 both flags", r, 8'h09);
    io_write(16'h03D4, 8'h11);
    io_read(16'h03D5, r); check("R8 other index", r, 8'h00);
    io_write(16'h03D4, 8'h24);

    for (int n = 0; n < 3000; n++) begin
      int op = int'($urandom_range(0, 99));
      if (op < 40) io_write(16'h03C0, 8'($urandom()));
      else if (op < 55) begin io_read(16'h03C0, r); check("R3 rand index", r, {2'b00, ix_m}); end
      else if (op < 70) begin io_read(16'h03C1, r); check("R4 rand data", r, exp_data()); end
      else if (op < 80) begin io_read(16'h03DA, r); check("R7 rand status", r, exp_status()); end
      else if (op < 90) begin io_read(16'h03D5, r); check("R8 rand ext", r, exp_ext()); end
      else if (op < 95) set_pins(1'($urandom()), 1'($urandom()));
      else begin
        check_all_regs("R5 rand regs");
        check("R10 rand enable", {7'b0, attr_video_en}, {7'b0, ix_m[5]});
      end
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule